// File: doc/BRIEF.md
# Line Buffer Command Sequencer

This block is the host-facing control unit of a serializing line buffer. A processor or DMA controller writes 16-bit words to it. A command/data select input routes each word. A command word carries its opcode in the top four bits and goes to the command decoder. A data word is handed on to line storage together with its word address.

The block keeps three configuration registers: the mode flags, the length of the fixed-level prefix and the line length in words. It moves between four operating states: idle (static), filling (write), sending and sent. Each command is honoured only in the states where it is legal, and is silently dropped in the others. The block gives the downstream serializer its configuration and one-cycle start, fill, repeat and stop strobes. It also drives an active-low DMA request while a line is being filled.

Everything is synchronous to one clock with a synchronous active-high reset. A bus write is recognised when the sampled write strobe rises while chip select or DMA acknowledge is low.

Top module: `line_ctrl_seq`

## Requirements
- R1: After reset the state is static (mode_o = 0). All flags, prefix_len_o and line_len_o are 0. dreq_n_o is 1, and wr_valid_o, start_o, fill_o, repeat_o and stop_o are 0.
- R2: Opcode 0x1 in static loads the flags from bits [4:0]: bit0 free-running clock select, bit1 toggle extension, bit2 DMA request mode, bit3 prefix enable, bit4 prefix level high.
- R3: In static, opcode 0x2 loads prefix_len_o from bits [7:0]. Opcode 0x3 loads line_len_o from bits [8:0], but only when that value is at most DEPTH.
- R4: Opcodes 0x1, 0x2, 0x3 and 0x5 outside static, and opcodes 0x8 to 0xF in any state, change nothing.
- R5: Opcode 0x4 enters write (mode_o = 1) from static or sent with word address 0. It is ignored when line_len_o is 0.
- R6: A data word accepted in write gives a one-cycle wr_valid_o with wr_data_o and a wr_addr_o that counts up from 0. Data words outside write give no wr_valid_o.
- R7: The word that completes line_len_o words moves the state to sending (mode_o = 2) and pulses start_o.
- R8: line_done_i in sending moves the state to sent (mode_o = 3). In other states it is ignored.
- R9: Opcode 0x6 in sent returns the state to sending and pulses repeat_o. In other states it is ignored.
- R10: Opcode 0x7 in any state returns to static and pulses stop_o. The configuration registers are kept.
- R11: Opcode 0x5 in static enters sending and pulses start_o and fill_o together.
- R12: dreq_n_o is 0 only in write with the DMA request flag set. Otherwise it is 1.
- R13: A word is taken only on a rising bus_wr_n with bus_cs_n or bus_dack_n low. With bus_dack_n low the word is data whatever bus_cmd_sel says.
- R14: send_busy_o is 1 exactly when mode_o is 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_wr_n | input | 1 | Write strobe; the word is taken on its rise |
| bus_cmd_sel | input | 1 | 1 = command word, 0 = data word |
| bus_dack_n | input | 1 | DMA acknowledge, active low; forces a data word |
| bus_data | input | 16 | Bus word |
| line_done_i | input | 1 | Serializer finished the line |
| mode_o | output | 2 | 0 static, 1 write, 2 sending, 3 sent |
| send_busy_o | output | 1 | High while sending |
| dreq_n_o | output | 1 | DMA request, active low |
| cfg_free_clk_o | output | 1 | Free-running clock selected |
| cfg_toggle_ext_o | output | 1 | Toggle extension enabled |
| cfg_dma_o | output | 1 | DMA request mode |
| cfg_prefix_en_o | output | 1 | Fixed prefix enabled |
| cfg_prefix_high_o | output | 1 | Prefix level high |
| prefix_len_o | output | 8 | Prefix length |
| line_len_o | output | 9 | Line length in words |
| wr_valid_o | output | 1 | Data word strobe to storage |
| wr_addr_o | output | 9 | Word address |
| wr_data_o | output | 16 | Word data |
| start_o | output | 1 | Start-of-send strobe |
| fill_o | output | 1 | Prefix-only line strobe |
| repeat_o | output | 1 | Repeat strobe |
| stop_o | output | 1 | Stop strobe |

## Verification
The bench builds the block with its default parameters: a 16-bit bus, DEPTH of 320 and an 8-bit prefix length. Because the line length is set by command, a three-word line is enough to reach the change from write to sending. A length request of 321 tests the bound one step above DEPTH. The whole cycle of static, write, sending, sent, repeat and stop is reached with a handful of bus writes. The state-gating of every command class, the DMA-acknowledge path and a zero line length after reset are each reached as well.

// File: rtl/lcs_pkg.sv
package lcs_pkg;

    localparam int OP_W = 4;

    typedef enum logic [1:0] {
        MODE_STATIC = 2'd0,
        MODE_WRITE  = 2'd1,
        MODE_BUSY   = 2'd2,
        MODE_DONE   = 2'd3
    } mode_e;

    localparam logic [OP_W-1:0] OP_NOP    = 4'h0;
    localparam logic [OP_W-1:0] OP_FLAGS  = 4'h1;
    localparam logic [OP_W-1:0] OP_PLEN   = 4'h2;
    localparam logic [OP_W-1:0] OP_LLEN   = 4'h3;
    localparam logic [OP_W-1:0] OP_WENTER = 4'h4;
    localparam logic [OP_W-1:0] OP_FILL   = 4'h5;
    localparam logic [OP_W-1:0] OP_REPEAT = 4'h6;
    localparam logic [OP_W-1:0] OP_STOP   = 4'h7;

    typedef struct packed {
        logic prefix_high;
        logic prefix_en;
        logic dma_req;
        logic toggle_ext;
        logic free_clk;
    } flags_t;

    typedef struct packed {
        logic set_flags;
        logic set_plen;
        logic set_llen;
        logic wenter;
        logic fill;
        logic rpt;
        logic stop;
        logic word;
    } act_t;

    // Legality of an opcode in a given operating state.
    function automatic logic op_allowed(logic [OP_W-1:0] op, mode_e m);
        case (op)
            OP_NOP, OP_STOP:                     return 1'b1;
            OP_FLAGS, OP_PLEN, OP_LLEN, OP_FILL: return m == MODE_STATIC;
            OP_WENTER:                           return (m == MODE_STATIC) || (m == MODE_DONE);
            OP_REPEAT:                           return m == MODE_DONE;
            default:                             return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/lcs_bus_capture.sv
module lcs_bus_capture #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              dack_n,
    input  logic              cmd_sel,
    input  logic [DATA_W-1:0] data,
    output logic              ev_o,
    output logic              is_cmd_o,
    output logic [DATA_W-1:0] word_o
);
    logic wr_q;

    always_ff @(posedge clk) begin
        if (rst) wr_q <= 1'b1;
        else     wr_q <= wr_n;
    end

    // Rising strobe qualified by chip select or DMA acknowledge.
    assign ev_o     = wr_n & ~wr_q & (~cs_n | ~dack_n);
    assign is_cmd_o = cmd_sel & dack_n;
    assign word_o   = data;

endmodule

// File: rtl/lcs_cmd_decode.sv
module lcs_cmd_decode
    import lcs_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 320,
    parameter int AW     = $clog2(DEPTH + 1)
) (
    input  logic              ev,
    input  logic              is_cmd,
    input  logic [DATA_W-1:0] word,
    input  mode_e             mode,
    input  logic [AW-1:0]     line_len,
    output act_t              act
);
    localparam logic [AW-1:0] DEPTH_V = AW'(DEPTH);

    logic [OP_W-1:0] op;
    logic [AW-1:0]   len_arg;

    assign op      = word[DATA_W-1 -: OP_W];
    assign len_arg = word[AW-1:0];

    always_comb begin
        act = '0;
        if (ev) begin
            if (!is_cmd) begin
                act.word = (mode == MODE_WRITE);
            end else if (op_allowed(op, mode)) begin
                case (op)
                    OP_FLAGS:  act.set_flags = 1'b1;
                    OP_PLEN:   act.set_plen  = 1'b1;
                    OP_LLEN:   act.set_llen  = (len_arg <= DEPTH_V);
                    OP_WENTER: act.wenter    = (line_len != '0);
                    OP_FILL:   act.fill      = 1'b1;
                    OP_REPEAT: act.rpt       = 1'b1;
                    OP_STOP:   act.stop      = 1'b1;
                    default:   act           = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/lcs_sequencer.sv
module lcs_sequencer
    import lcs_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int AW     = 9,
    parameter int PLEN_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  act_t              act,
    input  logic [DATA_W-1:0] word,
    input  logic              line_done,
    output mode_e             mode_q,
    output flags_t            flags_q,
    output logic [PLEN_W-1:0] plen_q,
    output logic [AW-1:0]     llen_q,
    output logic              wr_valid_o,
    output logic [AW-1:0]     wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              start_o,
    output logic              fill_o,
    output logic              rpt_o,
    output logic              stop_o,
    output logic              dreq_n_o
);
    localparam int FLAG_W = $bits(flags_t);

    logic [AW-1:0] cnt_q;
    logic          last_word;

    assign last_word = (cnt_q == AW'(llen_q - 1'b1));
    assign dreq_n_o  = ~(flags_q.dma_req && (mode_q == MODE_WRITE));

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q     <= MODE_STATIC;
            flags_q    <= '0;
            plen_q     <= '0;
            llen_q     <= '0;
            cnt_q      <= '0;
            wr_valid_o <= 1'b0;
            wr_addr_o  <= '0;
            wr_data_o  <= '0;
            start_o    <= 1'b0;
            fill_o     <= 1'b0;
            rpt_o      <= 1'b0;
            stop_o     <= 1'b0;
        end else begin
            wr_valid_o <= 1'b0;
            start_o    <= 1'b0;
            fill_o     <= 1'b0;
            rpt_o      <= 1'b0;
            stop_o     <= 1'b0;
            if (act.stop) begin
                mode_q <= MODE_STATIC;
                stop_o <= 1'b1;
                cnt_q  <= '0;
            end else begin
                case (mode_q)
                    MODE_STATIC: begin
                        if (act.set_flags) flags_q <= flags_t'(word[FLAG_W-1:0]);
                        if (act.set_plen)  plen_q  <= word[PLEN_W-1:0];
                        if (act.set_llen)  llen_q  <= word[AW-1:0];
                        if (act.wenter) begin
                            mode_q <= MODE_WRITE;
                            cnt_q  <= '0;
                        end
                        if (act.fill) begin
                            mode_q  <= MODE_BUSY;
                            start_o <= 1'b1;
                            fill_o  <= 1'b1;
                        end
                    end
                    MODE_WRITE: begin
                        if (act.word) begin
                            wr_valid_o <= 1'b1;
                            wr_addr_o  <= cnt_q;
                            wr_data_o  <= word;
                            if (last_word) begin
                                mode_q  <= MODE_BUSY;
                                start_o <= 1'b1;
                                cnt_q   <= '0;
                            end else begin
                                cnt_q <= cnt_q + 1'b1;
                            end
                        end
                    end
                    MODE_BUSY: begin
                        if (line_done) mode_q <= MODE_DONE;
                    end
                    MODE_DONE: begin
                        if (act.rpt) begin
                            mode_q <= MODE_BUSY;
                            rpt_o  <= 1'b1;
                        end else if (act.wenter) begin
                            mode_q <= MODE_WRITE;
                            cnt_q  <= '0;
                        end
                    end
                    default: mode_q <= MODE_STATIC;
                endcase
            end
        end
    end

    a_r7_start_enters_busy: assert property (@(posedge clk) disable iff (rst)
        start_o |-> mode_q == MODE_BUSY);

    a_r10_stop_to_static: assert property (@(posedge clk) disable iff (rst)
        stop_o |-> mode_q == MODE_STATIC);

    a_r9_repeat_from_done: assert property (@(posedge clk) disable iff (rst)
        rpt_o |-> (mode_q == MODE_BUSY) && ($past(mode_q) == MODE_DONE));

    a_r6_addr_in_line: assert property (@(posedge clk) disable iff (rst)
        wr_valid_o |-> wr_addr_o < llen_q);

    a_r8_done_after_busy: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_DONE) && ($past(mode_q) != MODE_DONE) |-> $past(mode_q) == MODE_BUSY);

    a_r4_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
        (mode_q != MODE_STATIC) && ($past(mode_q) != MODE_STATIC)
        |-> $stable(plen_q) && $stable(llen_q) && $stable(flags_q));

endmodule

// File: rtl/line_ctrl_seq.sv
module line_ctrl_seq
    import lcs_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 320,
    parameter int PLEN_W = 8,
    localparam int AW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_cs_n,
    input  logic              bus_wr_n,
    input  logic              bus_cmd_sel,
    input  logic              bus_dack_n,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              line_done_i,
    output logic [1:0]        mode_o,
    output logic              send_busy_o,
    output logic              dreq_n_o,
    output logic              cfg_free_clk_o,
    output logic              cfg_toggle_ext_o,
    output logic              cfg_dma_o,
    output logic              cfg_prefix_en_o,
    output logic              cfg_prefix_high_o,
    output logic [PLEN_W-1:0] prefix_len_o,
    output logic [AW-1:0]     line_len_o,
    output logic              wr_valid_o,
    output logic [AW-1:0]     wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              start_o,
    output logic              fill_o,
    output logic              repeat_o,
    output logic              stop_o
);
    logic              ev;
    logic              is_cmd;
    logic [DATA_W-1:0] word;
    act_t              act;
    mode_e             mode_q;
    flags_t            flags_q;

    lcs_bus_capture #(.DATA_W(DATA_W)) u_cap (
        .clk(clk), .rst(rst), .cs_n(bus_cs_n), .wr_n(bus_wr_n),
        .dack_n(bus_dack_n), .cmd_sel(bus_cmd_sel), .data(bus_data),
        .ev_o(ev), .is_cmd_o(is_cmd), .word_o(word)
    );

    lcs_cmd_decode #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_dec (
        .ev(ev), .is_cmd(is_cmd), .word(word), .mode(mode_q),
        .line_len(line_len_o), .act(act)
    );

    lcs_sequencer #(.DATA_W(DATA_W), .AW(AW), .PLEN_W(PLEN_W)) u_seq (
        .clk(clk), .rst(rst), .act(act), .word(word), .line_done(line_done_i),
        .mode_q(mode_q), .flags_q(flags_q), .plen_q(prefix_len_o),
        .llen_q(line_len_o), .wr_valid_o(wr_valid_o), .wr_addr_o(wr_addr_o),
        .wr_data_o(wr_data_o), .start_o(start_o), .fill_o(fill_o),
        .rpt_o(repeat_o), .stop_o(stop_o), .dreq_n_o(dreq_n_o)
    );

    assign mode_o            = mode_q;
    assign send_busy_o       = (mode_q == MODE_BUSY);
    assign cfg_free_clk_o    = flags_q.free_clk;
    assign cfg_toggle_ext_o  = flags_q.toggle_ext;
    assign cfg_dma_o         = flags_q.dma_req;
    assign cfg_prefix_en_o   = flags_q.prefix_en;
    assign cfg_prefix_high_o = flags_q.prefix_high;

    a_r12_dreq_only_in_write: assert property (@(posedge clk) disable iff (rst)
        !dreq_n_o |-> (mode_o == 2'd1) && cfg_dma_o);

endmodule

// File: tb/tb_line_ctrl_seq.sv
`timescale 1ns/1ps
module tb_line_ctrl_seq;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, wr_n = 1'b1, cmd_sel = 1'b0, dack_n = 1'b1, line_done = 1'b0;
    logic [15:0] data = '0;

    logic [1:0]  mode_o;
    logic        send_busy_o, dreq_n_o;
    logic        f_free, f_tog, f_dma, f_pen, f_phigh;
    logic [7:0]  prefix_len_o;
    logic [8:0]  line_len_o, wr_addr_o;
    logic        wr_valid_o, start_o, fill_o, repeat_o, stop_o;
    logic [15:0] wr_data_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    line_ctrl_seq dut (
        .clk(clk), .rst(rst), .bus_cs_n(cs_n), .bus_wr_n(wr_n), .bus_cmd_sel(cmd_sel),
        .bus_dack_n(dack_n), .bus_data(data), .line_done_i(line_done),
        .mode_o(mode_o), .send_busy_o(send_busy_o), .dreq_n_o(dreq_n_o),
        .cfg_free_clk_o(f_free), .cfg_toggle_ext_o(f_tog), .cfg_dma_o(f_dma),
        .cfg_prefix_en_o(f_pen), .cfg_prefix_high_o(f_phigh),
        .prefix_len_o(prefix_len_o), .line_len_o(line_len_o),
        .wr_valid_o(wr_valid_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
        .start_o(start_o), .fill_o(fill_o), .repeat_o(repeat_o), .stop_o(stop_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One bus write; returns at the falling edge after the capturing edge.
    task automatic bus_wr(input logic cs, input logic dk, input logic sel, input logic [15:0] d);
        @(negedge clk);
        cs_n = cs; dack_n = dk; cmd_sel = sel; data = d; wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
        cs_n = 1'b1; dack_n = 1'b1;
    endtask

    task automatic cmd(input logic [15:0] d);
        bus_wr(1'b0, 1'b1, 1'b1, d);
    endtask

    task automatic pulse_done();
        @(negedge clk);
        line_done = 1'b1;
        @(negedge clk);
        line_done = 1'b0;
    endtask

    // [20] command, [19:4] word, [3:2] expected mode, [1] expected wr_valid, [0] expected start
    localparam logic [20:0] TBL [0:11] = '{
        {1'b1, 16'h1015, 2'd0, 1'b0, 1'b0}, // R2 flags
        {1'b1, 16'h2005, 2'd0, 1'b0, 1'b0}, // R3 prefix length 5
        {1'b1, 16'h3003, 2'd0, 1'b0, 1'b0}, // R3 line length 3
        {1'b1, 16'h3141, 2'd0, 1'b0, 1'b0}, // R3 321 > DEPTH ignored
        {1'b0, 16'hAAAA, 2'd0, 1'b0, 1'b0}, // R6 data in static ignored
        {1'b1, 16'h6000, 2'd0, 1'b0, 1'b0}, // R9 repeat in static ignored
        {1'b1, 16'h4000, 2'd1, 1'b0, 1'b0}, // R5 enter write
        {1'b1, 16'h2009, 2'd1, 1'b0, 1'b0}, // R4 prefix length in write ignored
        {1'b0, 16'h1111, 2'd1, 1'b1, 1'b0}, // R6 word 0
        {1'b0, 16'h2222, 2'd1, 1'b1, 1'b0}, // R6 word 1
        {1'b0, 16'h3333, 2'd2, 1'b1, 1'b1}, // R7 last word starts send
        {1'b1, 16'h4000, 2'd2, 1'b0, 1'b0}  // R5 enter write while sending ignored
    };

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 mode", mode_o, 0);
        chk("R1 dreq_n", dreq_n_o, 1);
        chk("R1 flags", {f_free, f_tog, f_dma, f_pen, f_phigh}, 0);
        chk("R1 lengths", {prefix_len_o, line_len_o}, 0);
        chk("R1 strobes", {wr_valid_o, start_o, fill_o, repeat_o, stop_o}, 0);

        for (int i = 0; i < 12; i++) begin
            bus_wr(1'b0, 1'b1, TBL[i][20], TBL[i][19:4]);
            chk($sformatf("table row %0d mode", i), mode_o, TBL[i][3:2]);
            chk($sformatf("table row %0d wr_valid", i), wr_valid_o, TBL[i][1]);
            chk($sformatf("table row %0d start", i), start_o, TBL[i][0]);
        end

        chk("R2 flags", {f_phigh, f_pen, f_dma, f_tog, f_free}, 5'b10101);
        chk("R3 prefix_len", prefix_len_o, 5);
        chk("R3 line_len", line_len_o, 3);
        chk("R4 last word data", wr_data_o, 16'h3333);
        chk("R14 busy", send_busy_o, 1);

        pulse_done();
        chk("R8 sent", mode_o, 3);
        chk("R14 not busy", send_busy_o, 0);

        cmd(16'h6000);
        chk("R9 repeat mode", mode_o, 2);
        chk("R9 repeat strobe", repeat_o, 1);

        pulse_done();
        cmd(16'h4000);
        chk("R5 write from sent", mode_o, 1);
        chk("R12 dreq active", dreq_n_o, 0);

        bus_wr(1'b1, 1'b0, 1'b1, 16'hBEEF);
        chk("R13 dack word valid", wr_valid_o, 1);
        chk("R13 dack word addr", wr_addr_o, 0);
        chk("R13 dack word data", wr_data_o, 16'hBEEF);

        bus_wr(1'b1, 1'b1, 1'b0, 16'h1234);
        chk("R13 unselected ignored", wr_valid_o, 0);

        bus_wr(1'b0, 1'b1, 1'b0, 16'h5678);
        chk("R6 addr counts", wr_addr_o, 1);
        chk("R6 data", wr_data_o, 16'h5678);

        cmd(16'h3002);
        chk("R4 line_len kept", line_len_o, 3);

        cmd(16'h7000);
        chk("R10 static", mode_o, 0);
        chk("R10 stop strobe", stop_o, 1);
        chk("R10 config kept", line_len_o, 3);
        chk("R12 dreq idle", dreq_n_o, 1);

        pulse_done();
        chk("R8 done in static ignored", mode_o, 0);

        cmd(16'h9000);
        chk("R4 unknown opcode", {mode_o, prefix_len_o}, {2'd0, 8'd5});

        cmd(16'h1000);
        chk("R2 flags cleared", {f_phigh, f_pen, f_dma, f_tog, f_free}, 0);
        cmd(16'h4000);
        chk("R12 dreq held without dma flag", dreq_n_o, 1);
        cmd(16'h7000);

        cmd(16'h5000);
        chk("R11 fill mode", mode_o, 2);
        chk("R11 start and fill", {start_o, fill_o}, 2'b11);

        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset again", {mode_o, line_len_o}, 0);
        cmd(16'h4000);
        chk("R5 zero length blocks write", mode_o, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule